// File: doc/BRIEF.md
# Prescaled Transmit-Only Serial Master (Mode 0)

This block sends a parallel word to a single write-only serial peripheral, such as a small DAC, over a clock/data pair plus a load strobe. The bus uses mode 0: the clock rests low, and each data bit is set up while the clock is low. The peripheral samples each bit on the rising clock edge. The word goes out most significant bit first. A dedicated strobe pulse follows the last bit and tells the peripheral to latch the word.

A free-running power-of-two divider sets the timing. The divider counts every system clock. The transfer sequencer moves forward only on the cycle where the divider count is zero. One serial clock period therefore covers two divider intervals, one for the high half and one for the low half. The strobe lasts one divider interval.

A self-test input replaces the supplied word with an internal word. That word is one greater than the word sent last. Successive transfers therefore carry a rising count, which makes the output easy to check on a logic analyser. The block has no receive path.

Top module: `spi_tx_prescaled`

## Requirements
- R1: When `rst` is high at a rising clock edge, the outputs `sck_o`, `strobe_o`, `busy_o` and `mosi_o` are 0 after that edge, and any transfer in progress is abandoned. The internal self-test word returns to 0.
- R2: A transfer sends all DATA_W bits of the accepted word on `mosi_o`, most significant bit first. Each bit is stable when `sck_o` rises.
- R3: With P = 2**PRESC_EXP system clocks, successive rising edges of `sck_o` within a transfer are 2*P clocks apart. Each high phase lasts exactly P clocks.
- R4: `sck_o` is low whenever `busy_o` is low.
- R5: One `strobe_o` pulse follows the last falling `sck_o` edge of a transfer. The pulse starts P clocks after that edge and stays high for exactly P clocks. While it is high, `sck_o` is low and `mosi_o` keeps the last data bit.
- R6: `busy_o` is high in the cycle after a start is accepted. It falls in the same cycle as `strobe_o`.
- R7: A `start_i` pulse while `busy_o` is high is ignored. The word being sent is unchanged, and no further transfer follows.
- R8: When `selftest_i` is high at acceptance, the block ignores `data_i`. It sends the previous word plus 1, modulo 2**DATA_W. The first such word after reset is 0, and after a normal word D it is D+1.
- R9: Every transfer produces exactly DATA_W rising edges on `sck_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Transfer request, accepted only while idle |
| data_i | input | DATA_W | Word to send, captured at acceptance |
| selftest_i | input | 1 | When high at acceptance, send previous word plus one |
| sck_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data, MSB first |
| strobe_o | output | 1 | Load strobe after the last bit |
| busy_o | output | 1 | High from acceptance until the strobe ends |

## Verification
The hardest case to reach from the ports is a start request that arrives in the middle of a shift. In that state the block must drop the request without corrupting the word already loaded. The stimulus issues a second start with a different word about a thousand clocks into a 16-bit transfer. The scoreboard holds only the first word, so any corruption shows up as a mismatch, and any extra transfer shows up as an unexpected strobe or clock edge. A reset in the middle of a shift, and a self-test word that wraps from all ones to zero, are reached in the same way.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LOW  = 2'd1,
    SEQ_HIGH = 2'd2,
    SEQ_STRB = 2'd3
  } seq_state_t;
endpackage

// File: rtl/spi_tx_prescaler.sv
module spi_tx_prescaler #(
  parameter int PRESC_EXP = 7
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  generate
    if (PRESC_EXP == 0) begin : g_undivided
      assign tick_o = 1'b1;
    end else begin : g_divided
      logic [PRESC_EXP-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
      end
      assign tick_o = (div_q == '0);

      // R3
      tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/spi_tx_sequencer.sv
module spi_tx_sequencer
  import spi_tx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic start_i,
  output logic load_o,
  output logic shift_o,
  output logic sck_o,
  output logic strobe_o,
  output logic busy_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] BITS_DONE = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(DATA_W - 1);

  seq_state_t       state_q;
  logic [CNT_W-1:0] bits_q;
  logic             sck_q, strb_q, busy_q;

  assign load_o  = (state_q == SEQ_IDLE) && start_i;
  assign shift_o = tick_i && (state_q == SEQ_HIGH) && (bits_q != LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      bits_q  <= '0;
      sck_q   <= 1'b0;
      strb_q  <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            state_q <= SEQ_LOW;
            busy_q  <= 1'b1;
            bits_q  <= '0;
          end
        end
        SEQ_LOW: begin
          if (tick_i) begin
            if (bits_q == BITS_DONE) begin
              state_q <= SEQ_STRB;
              strb_q  <= 1'b1;
            end else begin
              state_q <= SEQ_HIGH;
              sck_q   <= 1'b1;
            end
          end
        end
        SEQ_HIGH: begin
          if (tick_i) begin
            state_q <= SEQ_LOW;
            sck_q   <= 1'b0;
            bits_q  <= bits_q + 1'b1;
          end
        end
        SEQ_STRB: begin
          if (tick_i) begin
            state_q <= SEQ_IDLE;
            strb_q  <= 1'b0;
            busy_q  <= 1'b0;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign sck_o    = sck_q;
  assign strobe_o = strb_q;
  assign busy_o   = busy_q;

  // R3
  sck_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sck_q) |-> $past(tick_i));

  // R4
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !sck_q);

  // R5
  strobe_sck_low_chk: assert property (@(posedge clk) disable iff (rst)
    strb_q |-> !sck_q);

  // R6
  busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(start_i));

  // R6
  busy_ends_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> $fell(strb_q));
endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              selftest_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              mosi_o
);
  logic [DATA_W-1:0] shreg_q;
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] load_word;

  assign load_word = selftest_i ? word_q : data_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      word_q  <= '0;
    end else if (load_i) begin
      shreg_q <= load_word;
      word_q  <= load_word + 1'b1;
    end else if (shift_i) begin
      shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
    end
  end

  assign mosi_o = shreg_q[DATA_W-1];

  // R2
  load_shift_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(load_i && shift_i));
endmodule

// File: rtl/spi_tx_prescaled.sv
module spi_tx_prescaled #(
  parameter int DATA_W    = 16,
  parameter int PRESC_EXP = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              selftest_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              strobe_o,
  output logic              busy_o
);
  logic tick;
  logic load;
  logic shift;

  spi_tx_prescaler #(.PRESC_EXP(PRESC_EXP)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  spi_tx_sequencer #(.DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick),
    .start_i  (start_i),
    .load_o   (load),
    .shift_o  (shift),
    .sck_o    (sck_o),
    .strobe_o (strobe_o),
    .busy_o   (busy_o)
  );

  spi_tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .shift_i    (shift),
    .selftest_i (selftest_i),
    .data_i     (data_i),
    .mosi_o     (mosi_o)
  );

  // R5
  strobe_mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_o && $past(strobe_o)) |-> $stable(mosi_o));

  // R7
  no_load_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !load);
endmodule

// File: tb/sim_spi_tx_prescaled.sv
module sim_spi_tx_prescaled;
  localparam int CLK_PERIOD = 20;
  localparam int DW = 16;
  localparam int EXP = 7;
  localparam int P = 1 << EXP;

  logic clk = 1'b0;
  logic rst, start, selftest;
  logic [DW-1:0] data;
  logic sck, mosi, strobe, busy;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] exp_next;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_tx_prescaled #(.DATA_W(DW), .PRESC_EXP(EXP)) u0 (
    .clk(clk), .rst(rst), .start_i(start), .data_i(data),
    .selftest_i(selftest), .sck_o(sck), .mosi_o(mosi),
    .strobe_o(strobe), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // monitor: times edges, collects bits, compares against the scoreboard
  int cyc = 0, last_rise = 0, last_fall = 0, strb_start = 0, nbits = 0;
  logic prev_sck = 0, prev_strb = 0, prev_busy = 0, held = 0;
  logic [DW-1:0] rx = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      nbits = 0; prev_sck = 0; prev_strb = 0; prev_busy = 0;
    end else begin
      if (sck && !prev_sck) begin
        if (nbits > 0) chk(cyc - last_rise == 2*P, "R3", "rise spacing", cyc - last_rise, 2*P);
        rx = {rx[DW-2:0], mosi};
        nbits++;
        last_rise = cyc;
      end
      if (!sck && prev_sck) begin
        chk(cyc - last_rise == P, "R3", "high phase", cyc - last_rise, P);
        last_fall = cyc;
      end
      if (sck && !busy) chk(0, "R4", "sck high while idle", 1, 0);
      if (strobe && !prev_strb) begin
        chk(nbits == DW, "R9", "rising edge count", nbits, DW);
        chk(cyc - last_fall == P, "R5", "strobe delay", cyc - last_fall, P);
        if (exp_q.size() == 0) chk(0, "R2", "unexpected word", rx, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(rx == e, "R2", "word shifted", rx, e);
        end
        strb_start = cyc;
        held = mosi;
      end
      if (strobe) begin
        chk(!sck, "R5", "sck during strobe", sck, 0);
        chk(mosi == held, "R5", "mosi held", mosi, held);
      end
      if (!strobe && prev_strb) begin
        chk(cyc - strb_start == P, "R5", "strobe width", cyc - strb_start, P);
        chk(!busy, "R6", "busy after strobe", busy, 0);
        nbits = 0;
      end
      if (!busy && prev_busy) chk(prev_strb && !strobe, "R6", "busy fell apart from strobe", prev_strb, 1);
      prev_sck = sck; prev_strb = strobe; prev_busy = busy;
    end
  end

  task automatic send(input logic [DW-1:0] d, input logic st);
    @(negedge clk);
    start = 1'b1; data = d; selftest = st;
    if (st) begin exp_q.push_back(exp_next); exp_next = exp_next + 1'b1; end
    else    begin exp_q.push_back(d);        exp_next = d + 1'b1; end
    @(negedge clk);
    start = 1'b0; selftest = 1'b0;
    chk(busy == 1'b1, "R6", "busy after accept", busy, 1);
  endtask

  task automatic wait_done();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start = 1'b0; selftest = 1'b0; data = '0; exp_next = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({sck, strobe, busy, mosi} == 4'b0, "R1", "outputs in reset", {sck, strobe, busy, mosi}, 0);
    rst = 1'b0;

    send(16'hA5C3, 1'b0);
    wait_done();

    // R7: second start mid-transfer must be ignored
    send(16'h8001, 1'b0);
    repeat (1000) @(negedge clk);
    start = 1'b1; data = 16'h0F0F;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R7", "still busy", busy, 1);
    wait_done();
    repeat (3*P) @(negedge clk);
    chk(!busy && !sck, "R7", "no extra transfer", {busy, sck}, 0);
    chk(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);

    // R8 self-test continues from the last normal word
    send(16'h0, 1'b1); wait_done();
    send(16'h0, 1'b1); wait_done();

    // R8 wrap from all ones
    send(16'hFFFF, 1'b0); wait_done();
    send(16'h1111, 1'b1); wait_done();
    chk(exp_q.size() == 0, "R8", "self-test words seen", exp_q.size(), 0);

    // R1 reset in the middle of a shift
    send(16'h1234, 1'b0);
    repeat (700) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk({sck, strobe, busy, mosi} == 4'b0, "R1", "mid-transfer reset", {sck, strobe, busy, mosi}, 0);
    exp_q.delete();
    exp_next = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    send(16'hBEEF, 1'b1); wait_done();
    send(16'h0000, 1'b0); wait_done();
    chk(exp_q.size() == 0, "R8", "post-reset self-test seen", exp_q.size(), 0);
    repeat (2*P) @(negedge clk);
    chk(!sck && !busy && !strobe, "R4", "final idle", {sck, busy, strobe}, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule